// File: doc/BRIEF.md
# Combined forward/inverse AES column mixer

This block applies the AES column-mixing step, or its inverse, to one 32-bit state column per clock. Each of the four column bytes feeds its own GF(2^8) constant multiplier. A fixed XOR network then combines the products into the four result bytes. One mode input picks the direction for the column that arrives with it. The result is registered, so it appears one clock after the input, together with a matching valid flag.

The forward and inverse constants come from one shared shift-and-reduce tree in each byte multiplier. The forward constants ({01}, {02}, {03}) come from the first two tree levels. The inverse constants ({09}, {0b}, {0d}, {0e}) need two further levels. While the mode selects the forward direction, AND gates hold the inputs of those deeper levels at zero, so they do not toggle.

There is no state machine. The only sequential element is the output register stage. It has two conditions: a column is captured when `in_valid` is high, and the previous result is held when it is low.

Top module: `mixcol_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_col` are cleared to zero on the next clock edge.
- R2: With `in_decrypt` = 0, output byte j equals {02}·s[j] ⊕ {03}·s[(j+1) mod 4] ⊕ s[(j+2) mod 4] ⊕ s[(j+3) mod 4].
- R3: With `in_decrypt` = 1, output byte j equals {0e}·s[j] ⊕ {0b}·s[(j+1) mod 4] ⊕ {0d}·s[(j+2) mod 4] ⊕ {09}·s[(j+3) mod 4].
- R4: Every field product is reduced modulo x^8+x^4+x^3+x+1. Doubling a byte with bit 7 set XORs 0x1B into the shifted value.
- R5: Row 0 of a column is carried on bits [31:24] and row 3 on bits [7:0], at both input and output.
- R6: A column presented with `in_valid` = 1 at a rising edge appears on `out_col` after that edge. `out_valid` equals `in_valid` delayed by one clock.
- R7: When `in_valid` is 0 at an edge, `out_col` keeps its previous value.
- R8: Applying the forward transform to a column and then the inverse transform to the result gives back the original column.
- R9: The mode is taken per column. Alternating `in_decrypt` on consecutive valid columns gives each column the result of its own mode.
- R10: While `in_decrypt` = 0, the inputs of the decrypt-only multiplier levels are held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Column on `in_col` is to be transformed |
| in_decrypt | input | 1 | 0 = forward mix, 1 = inverse mix |
| in_col | input | 32 | Input column, row 0 in [31:24] |
| out_valid | output | 1 | `out_col` carries a fresh result |
| out_col | output | 32 | Transformed column, row 0 in [31:24] |

## Verification
Two things can happen in the same cycle: the mode can flip, and a valid column can arrive. Because the decrypt-only levels are gated, a column that switches to inverse mode must leave the ungated path at once. The bench provokes this by alternating the mode on every cycle, both across back-to-back valid columns and across round trips that feed each forward result straight back as an inverse input. A behavioural reference model, built on a bitwise shift-and-add field multiply, predicts every registered output. The bench compares against it on every clock, including idle cycles where the held value must not move.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_W     = BYTE_W * COL_BYTES;
    localparam int DEEP_W    = 3 * BYTE_W;
    localparam logic [BYTE_W-1:0] RED_TAIL = 8'h1B;

    typedef logic [BYTE_W-1:0] byte_t;

    // products of one input byte with every constant either direction needs
    typedef struct packed {
        byte_t k01;
        byte_t k02;
        byte_t k03;
        byte_t k09;
        byte_t k0b;
        byte_t k0d;
        byte_t k0e;
    } prod_t;

    // one MSB-first step: shift left, fold bit 7 back through the tail
    function automatic byte_t dbl(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_TAIL : '0);
    endfunction
endpackage

// File: rtl/mc_shallow_stage.sv
module mc_shallow_stage
    import mixcol_pkg::*;
(
    input  byte_t s_in,
    output byte_t lvl2_x2,
    output byte_t lvl2_x3
);
    // level 1 is the bare byte; level 2 branches on con bit 2
    always_comb begin
        lvl2_x2 = dbl(s_in);
        lvl2_x3 = dbl(s_in) ^ s_in;
    end
endmodule

// File: rtl/mc_deep_stage.sv
module mc_deep_stage
    import mixcol_pkg::*;
(
    input  byte_t g_s,
    input  byte_t g_x2,
    input  byte_t g_x3,
    output byte_t k09,
    output byte_t k0b,
    output byte_t k0d,
    output byte_t k0e
);
    byte_t l3_a;
    byte_t l3_b;
    byte_t l3_c;
    byte_t l3_d;

    // level 3: one step from each level-2 node, with and without the add
    always_comb begin
        l3_a = dbl(g_x2);
        l3_b = dbl(g_x2) ^ g_s;
        l3_c = dbl(g_x3);
        l3_d = dbl(g_x3) ^ g_s;
    end

    // level 4: final step for the four inverse constants
    always_comb begin
        k09 = dbl(l3_a) ^ g_s;
        k0b = dbl(l3_b) ^ g_s;
        k0d = dbl(l3_c) ^ g_s;
        k0e = dbl(l3_d);
    end
endmodule

// File: rtl/mc_byte_mul.sv
module mc_byte_mul
    import mixcol_pkg::*;
(
    input  byte_t              s_in,
    input  logic               dec_mode,
    output prod_t              prod,
    output logic [DEEP_W-1:0]  deep_in
);
    byte_t x2;
    byte_t x3;
    byte_t g_s;
    byte_t g_x2;
    byte_t g_x3;
    byte_t k09;
    byte_t k0b;
    byte_t k0d;
    byte_t k0e;

    mc_shallow_stage u_shallow (
        .s_in    (s_in),
        .lvl2_x2 (x2),
        .lvl2_x3 (x3)
    );

    // AND gating keeps levels 3 and 4 quiet in forward mode
    always_comb begin
        g_s  = s_in & {BYTE_W{dec_mode}};
        g_x2 = x2   & {BYTE_W{dec_mode}};
        g_x3 = x3   & {BYTE_W{dec_mode}};
    end

    mc_deep_stage u_deep (
        .g_s  (g_s),
        .g_x2 (g_x2),
        .g_x3 (g_x3),
        .k09  (k09),
        .k0b  (k0b),
        .k0d  (k0d),
        .k0e  (k0e)
    );

    always_comb begin
        prod.k01 = s_in;
        prod.k02 = x2;
        prod.k03 = x3;
        prod.k09 = k09;
        prod.k0b = k0b;
        prod.k0d = k0d;
        prod.k0e = k0e;
        deep_in  = {g_s, g_x2, g_x3};
    end
endmodule

// File: rtl/mc_xor_net.sv
module mc_xor_net
    import mixcol_pkg::*;
(
    input  prod_t              prods [COL_BYTES],
    input  logic               dec_mode,
    output logic [COL_W-1:0]   mixed
);
    byte_t fwd [COL_BYTES];
    byte_t inv [COL_BYTES];

    generate
        for (genvar j = 0; j < COL_BYTES; j++) begin : g_row
            localparam int N1 = (j + 1) % COL_BYTES;
            localparam int N2 = (j + 2) % COL_BYTES;
            localparam int N3 = (j + 3) % COL_BYTES;
            always_comb begin
                fwd[j] = prods[j].k02 ^ prods[N1].k03 ^ prods[N2].k01 ^ prods[N3].k01;
                inv[j] = prods[j].k0e ^ prods[N1].k0b ^ prods[N2].k0d ^ prods[N3].k09;
                mixed[COL_W-1-j*BYTE_W -: BYTE_W] = dec_mode ? inv[j] : fwd[j];
            end
        end
    endgenerate
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
    import mixcol_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_decrypt,
    input  logic [31:0]       in_col,
    output logic              out_valid,
    output logic [31:0]       out_col
);
    prod_t                          prods [COL_BYTES];
    logic [COL_BYTES*DEEP_W-1:0]    deep_taps;
    logic [COL_W-1:0]               mixed;

    generate
        for (genvar i = 0; i < COL_BYTES; i++) begin : g_mul
            mc_byte_mul u_mul (
                .s_in     (in_col[COL_W-1-i*BYTE_W -: BYTE_W]),
                .dec_mode (in_decrypt),
                .prod     (prods[i]),
                .deep_in  (deep_taps[i*DEEP_W +: DEEP_W])
            );
        end
    endgenerate

    mc_xor_net u_net (
        .prods    (prods),
        .dec_mode (in_decrypt),
        .mixed    (mixed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_col   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_col <= mixed;
            end
        end
    end
endmodule

// File: rtl/mixcol_unit_chk.sv
module mixcol_unit_chk
    import mixcol_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_decrypt,
    input logic [31:0]                 in_col,
    input logic                        out_valid,
    input logic [31:0]                 out_col,
    input logic [COL_BYTES*DEEP_W-1:0] deep_taps
);
    logic uniform;
    assign uniform = (in_col[31:24] == in_col[23:16]) &&
                     (in_col[23:16] == in_col[15:8]) &&
                     (in_col[15:8]  == in_col[7:0]);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (out_valid == 1'b0 && out_col == '0));

    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_col));

    // coefficient sums are {01} in both directions: a uniform column is a fixed point
    a_r2_uniform_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_decrypt && uniform) |=> out_col == $past(in_col));

    a_r3_uniform_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_decrypt && uniform) |=> out_col == $past(in_col));

    a_r10_deep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_decrypt |-> deep_taps == '0);
endmodule

bind mixcol_unit mixcol_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_decrypt (in_decrypt),
    .in_col     (in_col),
    .out_valid  (out_valid),
    .out_col    (out_col),
    .deep_taps  (deep_taps)
);

// File: tb/mixcol_unit_bench.sv
module mixcol_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_decrypt = 1'b0;
    logic [31:0] in_col = '0;
    logic        out_valid;
    logic [31:0] out_col;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_col = '0;
    logic        exp_valid = 1'b0;

    always #2 clk = ~clk;

    mixcol_unit u_mixcol_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_decrypt (in_decrypt),
        .in_col     (in_col),
        .out_valid  (out_valid),
        .out_col    (out_col)
    );

    // plain shift-and-add field product, bit by bit from the multiplier's LSB
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] aa  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ aa;
            aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
        end
        return acc;
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] c, input logic dec);
        logic [7:0] s [4];
        logic [7:0] r;
        logic [7:0] k [4];
        logic [31:0] res = '0;
        for (int i = 0; i < 4; i++) s[i] = c[31-8*i -: 8];
        if (dec) begin k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09; end
        else     begin k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01; end
        for (int j = 0; j < 4; j++) begin
            r = 8'h00;
            for (int t = 0; t < 4; t++) r = r ^ gmul(s[(j+t)%4], k[t]);
            res[31-8*j -: 8] = r;
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, expv);
        end
    endtask

    // drive one cycle, update model, compare after the edge
    task automatic step(input logic v, input logic dec, input logic [31:0] c, input string req);
        @(negedge clk);
        in_valid = v; in_decrypt = dec; in_col = c;
        if (v) exp_col = ref_mix(c, dec);
        exp_valid = v;
        @(posedge clk); #1;
        check({req, " valid"}, {31'd0, out_valid}, {31'd0, exp_valid});
        check(req, out_col, exp_col);
    endtask

    task automatic known(input logic dec, input logic [31:0] c, input logic [31:0] expv, input string req);
        step(1'b1, dec, c, req);
        check({req, " vector"}, out_col, expv);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rnd;
        logic [31:0] fw;
        in_valid = 1'b1; in_col = 32'hFFFFFFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset col", out_col, 32'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        check("R6 idle after reset", {31'd0, out_valid}, 32'd0);

        // R2 R4 R5 known forward vectors (bytes with bit 7 set exercise reduction)
        known(1'b0, 32'hdb135345, 32'h8e4da1bc, "R2");
        known(1'b0, 32'hf20a225c, 32'h9fdc589d, "R4");
        known(1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6, "R5");
        known(1'b0, 32'h2d26314c, 32'h4d7ebdf8, "R2");
        known(1'b0, 32'hc6c6c6c6, 32'hc6c6c6c6, "R2 uniform");
        // R3 inverse vectors
        known(1'b1, 32'h8e4da1bc, 32'hdb135345, "R3");
        known(1'b1, 32'h9fdc589d, 32'hf20a225c, "R3 R4");
        known(1'b1, 32'h01010101, 32'h01010101, "R3 uniform");

        // R7 hold while idle
        step(1'b0, 1'b1, 32'h12345678, "R7 hold");
        step(1'b0, 1'b0, 32'hdeadbeef, "R7 hold");

        // R9 mode toggling on back-to-back columns, R10 inverse right after forward
        for (int i = 0; i < 40; i++) begin
            rnd = $urandom;
            step(1'b1, i[0], rnd, "R9 R10 alternating");
        end

        // R8 round trip, plus R6 with idle gaps
        for (int i = 0; i < 300; i++) begin
            rnd = $urandom;
            step(1'b1, 1'b0, rnd, "R8 forward");
            fw = out_col;
            step(1'b1, 1'b1, fw, "R8 inverse");
            check("R8 round trip", out_col, rnd);
            if (i % 7 == 0) step(1'b0, 1'b1, 32'hA5A5A5A5, "R6 R7 gap");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule